// File: doc/BRIEF.md
# Shared Address / General-Purpose I/O Port

This block controls a small bank of chip pins that serve either as outputs of the external address bus or as general-purpose I/O. The operating mode and a per-bit direction register set the role of each pin. In the two external-bus modes every pin carries an address bit. In the mixed mode a pin carries an address bit when its direction bit is set, and is an input when it is clear. In single-chip mode a set direction bit turns the pin into a GPIO output driven from the data register, and a clear bit makes it an input. Per-pin pull-up and open-drain enables refine the input and output behaviour.

Software reaches five registers through a small synchronous register bus: direction (write-only), output data, pin state (read-only), pull-up enable and open-drain enable. The pin-side outputs (drive value, output enable and pull-up request) are all registered, so they follow register, mode or address changes one clock later. Hardware standby clears the direction register and quiets every pin. Software standby keeps the direction register. In software standby one control input decides whether address-role pins keep driving their last value or release to high impedance.

Top module: `addr_gpio_port`

## Requirements
- R1: On reset the direction, data, pull-up and open-drain registers hold 0, and pad_oe, pad_out and pull_en are all 0.
- R2: Register offsets are 0 direction, 1 data, 2 pin state, 3 pull-up, 4 open-drain. Offsets 1, 3 and 4 read back the value last written. Offsets 5 to 7 read 0. bus_rdata is registered and is valid the cycle after an access with bus_sel=1 and bus_wr=0.
- R3: The direction register can be written but not read. A read of offset 0 returns all ones, whatever was written.
- R4: A read of offset 2 returns the data bit for pins that are GPIO outputs (mode 3 with direction bit 1) and the pad_in level for every other pin. A write to offset 2 changes no register.
- R5: With mode 0 or 1, every pin has pad_oe=1 and pad_out equal to addr_in, whatever the direction bits hold.
- R6: With mode 2, a pin whose direction bit is 1 drives its addr_in bit with pad_oe=1. A pin whose direction bit is 0 is an input with pad_oe=0 and pad_out=0.
- R7: With mode 3, a pin whose direction bit is 1 drives its data bit with pad_oe=1. A pin whose direction bit is 0 is an input with pad_oe=0 and pad_out=0.
- R8: A GPIO output pin whose open-drain bit is 1 has pad_out=0 and pad_oe equal to the inverse of its data bit.
- R9: pull_en is 1 only for a pin that is an input and whose pull-up bit is 1. pull_en and pad_oe are never both 1 on the same pin.
- R10: While hw_stby is 1, the direction register is cleared, register writes are ignored, and the next cycle shows pad_oe=0 and pull_en=0 on every pin.
- R11: While sw_stby=1 and stby_hold=0, address-role pins have pad_oe=0. The direction register keeps its value through software standby.
- R12: While sw_stby=1 and stby_hold=1, address-role pins keep pad_oe=1 and hold their last pad_out value while addr_in changes.
- R13: pad_out, pad_oe and pull_en change one clock after the register write, mode change or addr_in change that causes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_stby | input | 1 | Hardware standby request |
| sw_stby | input | 1 | Software standby request |
| stby_hold | input | 1 | Address pins keep driving in software standby when 1 |
| mode | input | 2 | Operating mode: 0/1 external bus, 2 mixed, 3 single-chip |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| addr_in | input | WIDTH | Address bits from the bus controller |
| pad_in | input | WIDTH | Sampled pad levels |
| pad_out | output | WIDTH | Per-pin drive value |
| pad_oe | output | WIDTH | Per-pin output enable |
| pull_en | output | WIDTH | Per-pin pull-up request |

## Verification
The bench builds the port with WIDTH=4 and ADDR_W=3. At that width it can sweep every direction value against every data value in all four modes, and it derives the open-drain, pull-up, address and pad patterns from each pair. This covers every per-pin role combination, including open-drain pins with both data levels and pull-up requests on inputs next to driven pins. Directed sequences then cover reset, the read-only and write-only offsets, the one-cycle output latency and the hold and release behaviour in both standby kinds.

// File: rtl/agp_pkg.sv
package agp_pkg;
  typedef enum logic [1:0] {
    MODE_EXT_WIDE   = 2'd0,
    MODE_EXT_NARROW = 2'd1,
    MODE_MIXED      = 2'd2,
    MODE_SINGLE     = 2'd3
  } port_mode_e;

  localparam int unsigned OFF_DIR  = 0;
  localparam int unsigned OFF_DATA = 1;
  localparam int unsigned OFF_PINS = 2;
  localparam int unsigned OFF_PULL = 3;
  localparam int unsigned OFF_ODRN = 4;
endpackage

// File: rtl/agp_regs.sv
module agp_regs
  import agp_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_stby,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  pins_view,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  pull_q,
  output logic [WIDTH-1:0]  odrn_q
);
  localparam logic [WIDTH-1:0] DIR_RD_VALUE = {WIDTH{1'b1}};

  logic             wr_ok;
  logic [WIDTH-1:0] rd_mux;

  assign wr_ok = bus_sel && bus_wr && !hw_stby;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFF_DIR))       rd_mux = DIR_RD_VALUE;
    else if (bus_addr == ADDR_W'(OFF_DATA)) rd_mux = data_q;
    else if (bus_addr == ADDR_W'(OFF_PINS)) rd_mux = pins_view;
    else if (bus_addr == ADDR_W'(OFF_PULL)) rd_mux = pull_q;
    else if (bus_addr == ADDR_W'(OFF_ODRN)) rd_mux = odrn_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q     <= '0;
      data_q    <= '0;
      pull_q    <= '0;
      odrn_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (hw_stby) begin
        dir_q <= '0;
      end else if (wr_ok && bus_addr == ADDR_W'(OFF_DIR)) begin
        dir_q <= bus_wdata;
      end
      if (wr_ok && bus_addr == ADDR_W'(OFF_DATA)) data_q <= bus_wdata;
      if (wr_ok && bus_addr == ADDR_W'(OFF_PULL)) pull_q <= bus_wdata;
      if (wr_ok && bus_addr == ADDR_W'(OFF_ODRN)) odrn_q <= bus_wdata;
      if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/agp_pin_role.sv
module agp_pin_role
  import agp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] is_addr,
  output logic [WIDTH-1:0] is_gpio
);
  logic ext_mode;
  logic mixed_mode;
  logic single_mode;

  assign ext_mode    = (mode == MODE_EXT_WIDE) || (mode == MODE_EXT_NARROW);
  assign mixed_mode  = (mode == MODE_MIXED);
  assign single_mode = (mode == MODE_SINGLE);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign is_addr[i] = ext_mode || (mixed_mode && dir_q[i]);
    assign is_gpio[i] = single_mode && dir_q[i];
  end
endmodule

// File: rtl/agp_pad_drive.sv
module agp_pad_drive #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic             stby_hold,
  input  logic [WIDTH-1:0] is_addr,
  input  logic [WIDTH-1:0] is_gpio,
  input  logic [WIDTH-1:0] addr_in,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] pull_q,
  input  logic [WIDTH-1:0] odrn_q,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pull_en
);
  logic [WIDTH-1:0] nxt_out;
  logic [WIDTH-1:0] nxt_oe;
  logic [WIDTH-1:0] nxt_pu;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic o_b;
    logic e_b;
    logic p_b;

    always_comb begin
      o_b = 1'b0;
      e_b = 1'b0;
      p_b = 1'b0;
      if (hw_stby) begin
        o_b = 1'b0;
      end else if (is_addr[i]) begin
        if (!sw_stby) begin
          o_b = addr_in[i];
          e_b = 1'b1;
        end else if (stby_hold) begin
          o_b = pad_out[i];
          e_b = 1'b1;
        end
      end else if (is_gpio[i]) begin
        if (odrn_q[i]) begin
          e_b = !data_q[i];
        end else begin
          o_b = data_q[i];
          e_b = 1'b1;
        end
      end else begin
        p_b = pull_q[i];
      end
    end

    assign nxt_out[i] = o_b;
    assign nxt_oe[i]  = e_b;
    assign nxt_pu[i]  = p_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pull_en <= '0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
      pull_en <= nxt_pu;
    end
  end
endmodule

// File: rtl/addr_gpio_port.sv
module addr_gpio_port #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              stby_hold,
  input  logic [1:0]        mode,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  addr_in,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pull_en
);
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] pull_q;
  logic [WIDTH-1:0] odrn_q;
  logic [WIDTH-1:0] is_addr;
  logic [WIDTH-1:0] is_gpio;
  logic [WIDTH-1:0] pins_view;

  // R4: driven GPIO pins report the data bit, the rest report the pad.
  assign pins_view = (is_gpio & data_q) | (~is_gpio & pad_in);

  agp_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .hw_stby   (hw_stby),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pins_view (pins_view),
    .bus_rdata (bus_rdata),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .pull_q    (pull_q),
    .odrn_q    (odrn_q)
  );

  agp_pin_role #(.WIDTH(WIDTH)) u_role (
    .mode    (mode),
    .dir_q   (dir_q),
    .is_addr (is_addr),
    .is_gpio (is_gpio)
  );

  agp_pad_drive #(.WIDTH(WIDTH)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .hw_stby   (hw_stby),
    .sw_stby   (sw_stby),
    .stby_hold (stby_hold),
    .is_addr   (is_addr),
    .is_gpio   (is_gpio),
    .addr_in   (addr_in),
    .data_q    (data_q),
    .pull_q    (pull_q),
    .odrn_q    (odrn_q),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pull_en   (pull_en)
  );
endmodule

// File: rtl/agp_port_checker.sv
module agp_port_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             hw_stby,
  input logic             sw_stby,
  input logic             stby_hold,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] addr_in,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pull_en
);
  // R5, R13: external-bus modes drive the address one cycle later
  p_ext_drive_r5: assert property (@(posedge clk) disable iff (rst)
    (!hw_stby && !sw_stby && !mode[1]) |=>
      (pad_oe == {WIDTH{1'b1}} && pad_out == $past(addr_in)));

  // R9: a pin never pulls up and drives at once
  p_pull_excl_r9: assert property (@(posedge clk) disable iff (rst)
    ((pull_en & pad_oe) == '0));

  // R10: hardware standby quiets all pins
  p_hw_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    hw_stby |=> (pad_oe == '0 && pull_en == '0));

  // R11: release to high impedance in software standby
  p_sw_release_r11: assert property (@(posedge clk) disable iff (rst)
    (sw_stby && !stby_hold && !hw_stby && !mode[1]) |=> (pad_oe == '0));

  // R12: address pins hold their value in software standby
  p_sw_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (sw_stby && stby_hold && !hw_stby && !mode[1]) |=>
      ($stable(pad_out) && pad_oe == {WIDTH{1'b1}}));
endmodule

bind addr_gpio_port agp_port_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hw_stby   (hw_stby),
  .sw_stby   (sw_stby),
  .stby_hold (stby_hold),
  .mode      (mode),
  .addr_in   (addr_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pull_en   (pull_en)
);

// File: tb/addr_gpio_port_test.sv
module addr_gpio_port_test;
  localparam int W  = 4;
  localparam int AW = 3;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hw_stby = 1'b0;
  logic          sw_stby = 1'b0;
  logic          stby_hold = 1'b0;
  logic [1:0]    mode = 2'd3;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  addr_in = '0;
  logic [W-1:0]  pad_in = '0;
  logic [W-1:0]  pad_out;
  logic [W-1:0]  pad_oe;
  logic [W-1:0]  pull_en;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  addr_gpio_port #(.WIDTH(W), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .stby_hold(stby_hold), .mode(mode), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .addr_in(addr_in), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pull_en(pull_en)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int off, input logic [W-1:0] val);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(off); bus_wdata = val;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int off, output logic [W-1:0] val);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(off);
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    val = bus_rdata;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [W-1:0] f_oe(int m, logic [W-1:0] d, logic [W-1:0] v, logic [W-1:0] od);
    if (m < 2) return ONES;
    if (m == 2) return d;
    return d & ~(od & v);
  endfunction

  function automatic logic [W-1:0] f_out(int m, logic [W-1:0] d, logic [W-1:0] v,
                                         logic [W-1:0] od, logic [W-1:0] a);
    if (m < 2) return a;
    if (m == 2) return a & d;
    return d & v & ~od;
  endfunction

  function automatic logic [W-1:0] f_pu(int m, logic [W-1:0] d, logic [W-1:0] pu);
    if (m < 2) return '0;
    return pu & ~d;
  endfunction

  function automatic logic [W-1:0] f_pins(int m, logic [W-1:0] d, logic [W-1:0] v, logic [W-1:0] p);
    if (m == 3) return (d & v) | (~d & p);
    return p;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    logic [W-1:0] hold_val;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pad_out", pad_out, '0);
    chk("R1 pull_en", pull_en, '0);
    rd(1, r); chk("R1 data", r, '0);
    rd(3, r); chk("R1 pull", r, '0);
    rd(4, r); chk("R1 odrn", r, '0);

    // R2: read back and unused offsets
    wr(1, 4'h9); rd(1, r); chk("R2 data", r, 4'h9);
    wr(3, 4'h6); rd(3, r); chk("R2 pull", r, 4'h6);
    wr(4, 4'h3); rd(4, r); chk("R2 odrn", r, 4'h3);
    for (int off = 5; off < 8; off++) begin
      rd(off, r); chk("R2 unused", r, '0);
    end

    // R3: direction write-only
    wr(0, 4'h5); rd(0, r); chk("R3 dir read", r, ONES);
    wr(0, 4'h0); rd(0, r); chk("R3 dir read", r, ONES);

    // R4: pin-state write ignored
    wr(4, 4'h0); wr(1, 4'hA); wr(0, 4'hC); pad_in = 4'h3;
    wr(2, 4'h5);
    rd(1, r); chk("R4 write ignored data", r, 4'hA);
    rd(2, r); chk("R4 pins", r, (4'hC & 4'hA) | (~4'hC & 4'h3));

    // R13: latency of outputs after a direction write in mode 3
    step();
    wr(0, 4'hF);
    chk("R13 before", pad_oe, 4'hC);
    step();
    chk("R13 after", pad_oe, 4'hF);

    // R5..R9 and R4: sweep all modes, directions and data
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 16; d++) begin
        for (int v = 0; v < 16; v++) begin
          logic [W-1:0] dd, vv, od, pu, a, p;
          string tag;
          dd = W'(d); vv = W'(v);
          od = dd ^ W'(v * 3);
          pu = ~vv;
          a  = W'(d * 5 + v * 3 + m);
          p  = W'(v * 7 + d + 1);
          mode = 2'(m); addr_in = a; pad_in = p;
          tag = (m < 2) ? "R5" : ((m == 2) ? "R6" : ((od != '0) ? "R8" : "R7"));
          wr(0, dd); wr(1, vv); wr(3, pu); wr(4, od);
          step();
          chk({tag, " pad_oe"}, pad_oe, f_oe(m, dd, vv, od));
          chk({tag, " pad_out"}, pad_out, f_out(m, dd, vv, od, a));
          chk("R9 pull_en", pull_en, f_pu(m, dd, pu));
          rd(2, r);
          chk("R4 pins", r, f_pins(m, dd, vv, p));
        end
      end
    end

    // R12: hold in software standby
    mode = 2'd0; addr_in = 4'h6; wr(4, 4'h0);
    step();
    hold_val = pad_out;
    chk("R12 setup", hold_val, 4'h6);
    sw_stby = 1'b1; stby_hold = 1'b1;
    step();
    addr_in = 4'h9;
    step(); step();
    chk("R12 hold out", pad_out, hold_val);
    chk("R12 hold oe", pad_oe, ONES);

    // R11: release, and direction kept
    stby_hold = 1'b0;
    step();
    chk("R11 release", pad_oe, '0);
    sw_stby = 1'b0;
    step();
    chk("R11 resume", pad_out, 4'h9);
    mode = 2'd2; wr(0, 4'h5); sw_stby = 1'b1; step(); sw_stby = 1'b0; step();
    chk("R11 dir kept", pad_oe, 4'h5);

    // R10: hardware standby
    mode = 2'd3; wr(0, 4'hF); wr(1, 4'h3); wr(3, 4'hF); step();
    hw_stby = 1'b1;
    step();
    chk("R10 oe", pad_oe, '0);
    chk("R10 pull", pull_en, '0);
    wr(1, 4'hC);
    hw_stby = 1'b0;
    step();
    chk("R10 dir cleared", pad_oe, '0);
    chk("R10 pull after", pull_en, 4'hF);
    rd(1, r); chk("R10 write ignored", r, 4'h3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule